// File: doc/BRIEF.md
# Oscillator Source Control Register with RTC Pre-Divider

This block is one 32-bit software-visible control word for the clock sources of a chip. It holds the on/off controls for three oscillators: a 32 kHz crystal, a 128 kHz RC oscillator and a 4–40 MHz crystal. It also holds a low-power setting for the fast crystal and two trim codes for the internal RC oscillators. The trim codes are write-protected. They change only when a separate unlock bit has already been set by an earlier write. The word is reached through a simple port with a byte address, a write enable and write data. Reads are combinational.

Some bits must outlive an ordinary system reset: the 32 kHz enable and both trim codes. Only the power-on / supply-fault reset clears them. A 3-bit select in the same word sets a power-of-two pre-divider for the RTC source clock. That clock arrives as a one-cycle enable pulse. The divided result leaves as a one-cycle enable pulse, which the RTC divides further.

Top module: `osc_ctrl_reg`

## Requirements
- R1: The word answers at byte address 0x00. Its layout is:
  - bit 0: fast crystal enable
  - bit 1: fast crystal low-power setting
  - bit 2: 32 kHz enable
  - bit 3: 128 kHz RC enable
  - bits 6:4: pre-divider select
  - bit 7: trim unlock
  - bits 12:8: 5-bit 128 kHz trim code
  - bits 21:16: 6-bit 16 MHz trim code
  
  All other bits read 0 and ignore writes. A read at any other address returns 0, and a write to any other address changes nothing.
- R2: The output pins `enXtal`, `xtalLowPwr`, `en32k`, `en128k`, `trim128` and `trim16` always equal the matching stored fields.
- R3: A write updates the two trim codes only if the trim unlock bit was already 1 before that write. Otherwise the trim codes keep their value, and the rest of the write still applies.
- R4: A system reset (`rstSysN` low) leaves the 32 kHz enable and both trim codes unchanged. It returns every other field to its reset value: bit 0 = 1, all others 0. Writes are ignored while either reset is low.
- R5: A power-on reset (`rstPorN` low) puts the whole word to 0x003F_1F01. This means the fast crystal is on and both trim codes are all ones.
- R6: Select codes 0 to 4 mean divide by 1, 2, 4, 8 and 16. A write carrying code 5, 6 or 7 leaves the stored select unchanged, while the rest of that write applies.
- R7: With select N, `rtcTick` is high for one cycle, in the same cycle as every 2^N-th `srcTick`. It is never high without `srcTick`.
- R8: A write that changes the select restarts the pulse count, so the first `rtcTick` comes on the 2^N-th `srcTick` after that write. A write that keeps the same select does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstSysN | input | 1 | System reset, active low, asynchronous |
| rstPorN | input | 1 | Power-on / supply-fault reset, active low, asynchronous |
| regWrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | 8 | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| srcTick | input | 1 | Enable pulse of the selected RTC source clock |
| rtcTick | output | 1 | Divided enable pulse |
| enXtal | output | 1 | Fast crystal enable |
| xtalLowPwr | output | 1 | Fast crystal low-power setting |
| en32k | output | 1 | 32 kHz crystal enable |
| en128k | output | 1 | 128 kHz RC enable |
| trim128 | output | 5 | 128 kHz RC trim code |
| trim16 | output | 6 | 16 MHz RC trim code |

## Verification
A write is taken at the clock edge that ends its cycle. Its effect is visible on `regRdData` and on the pins in the very next cycle. The bench therefore drives each write for one cycle from the falling edge and reads back one cycle later, shortly after the next falling edge. `rtcTick` is combinational from `srcTick`, so the bench samples it within the same cycle in which it drives `srcTick`. Every tick cycle is compared against the position of that tick within its group of 2^N, counted from the last select change.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;
  localparam int TRIM128_W = 5;
  localparam int TRIM16_W  = 6;
  localparam int SEL_W     = 3;
  localparam int MAX_SEL   = 4;
  localparam int CNT_W     = MAX_SEL;

  localparam int POS_XTAL   = 0;
  localparam int POS_LOWPWR = 1;
  localparam int POS_32K    = 2;
  localparam int POS_128K   = 3;
  localparam int POS_SEL    = 4;
  localparam int POS_UNLOCK = 7;
  localparam int POS_T128   = 8;
  localparam int POS_T16    = 16;

  typedef struct packed {
    logic wrBase;
    logic wrTrim;
    logic wrSel;
    logic restartDiv;
  } ctlStrobes_t;
endpackage

// File: rtl/osc_ctrl_decode.sv
module osc_ctrl_decode
  import osc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rstSysN,
  input  logic              rstPorN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SEL_W-1:0]  newSel,
  input  logic [SEL_W-1:0]  curSel,
  input  logic              unlockQ,
  output ctlStrobes_t       stb
);
  logic hit;
  logic selOk;

  always_comb begin
    hit   = regWrEn && (regAddr == '0) && rstSysN && rstPorN;
    selOk = (int'(newSel) <= MAX_SEL);
    stb.wrBase     = hit;
    stb.wrTrim     = hit && unlockQ;
    stb.wrSel      = hit && selOk;
    stb.restartDiv = hit && selOk && (newSel != curSel);
  end
endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
  import osc_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstPorN,
  input  logic                 rstAnyN,
  input  ctlStrobes_t          stb,
  input  logic [31:0]          wrData,
  output logic                 enXtalQ,
  output logic                 lowPwrQ,
  output logic                 en32kQ,
  output logic                 en128kQ,
  output logic [SEL_W-1:0]     selQ,
  output logic                 unlockQ,
  output logic [TRIM128_W-1:0] trim128Q,
  output logic [TRIM16_W-1:0]  trim16Q
);
  // Bits cleared only by power-on / supply fault
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      en32kQ   <= 1'b0;
      trim128Q <= '1;
      trim16Q  <= '1;
    end else begin
      if (stb.wrBase) en32kQ <= wrData[POS_32K];
      if (stb.wrTrim) begin
        trim128Q <= wrData[POS_T128 +: TRIM128_W];
        trim16Q  <= wrData[POS_T16 +: TRIM16_W];
      end
    end
  end

  // Bits cleared by either reset
  always_ff @(posedge clk or negedge rstAnyN) begin
    if (!rstAnyN) begin
      enXtalQ <= 1'b1;
      lowPwrQ <= 1'b0;
      en128kQ <= 1'b0;
      unlockQ <= 1'b0;
      selQ    <= '0;
    end else begin
      if (stb.wrBase) begin
        enXtalQ <= wrData[POS_XTAL];
        lowPwrQ <= wrData[POS_LOWPWR];
        en128kQ <= wrData[POS_128K];
        unlockQ <= wrData[POS_UNLOCK];
      end
      if (stb.wrSel) selQ <= wrData[POS_SEL +: SEL_W];
    end
  end
endmodule

// File: rtl/osc_ctrl_prediv.sv
module osc_ctrl_prediv
  import osc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstAnyN,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             srcTick,
  output logic             rtcTick
);
  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lastIdx;
  logic             atEnd;

  always_comb begin
    span    = (CNT_W+1)'(1) << sel;
    lastIdx = CNT_W'(span - (CNT_W+1)'(1));
    atEnd   = (count == lastIdx);
    rtcTick = srcTick && atEnd;
  end

  always_ff @(posedge clk or negedge rstAnyN) begin
    if (!rstAnyN)     count <= '0;
    else if (restart) count <= '0;
    else if (srcTick) count <= atEnd ? '0 : count + CNT_W'(1);
  end
endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstSysN,
  input  logic                 rstPorN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic                 srcTick,
  output logic                 rtcTick,
  output logic                 enXtal,
  output logic                 xtalLowPwr,
  output logic                 en32k,
  output logic                 en128k,
  output logic [TRIM128_W-1:0] trim128,
  output logic [TRIM16_W-1:0]  trim16
);
  ctlStrobes_t      stb;
  logic             rstAnyN;
  logic [SEL_W-1:0] selQ;
  logic             unlockQ;

  assign rstAnyN = rstSysN & rstPorN;

  osc_ctrl_decode #(.ADDR_W(ADDR_W)) decode_i (
    .rstSysN(rstSysN), .rstPorN(rstPorN), .regWrEn(regWrEn), .regAddr(regAddr),
    .newSel(regWrData[POS_SEL +: SEL_W]), .curSel(selQ), .unlockQ(unlockQ), .stb(stb)
  );

  osc_ctrl_regs regs_i (
    .clk(clk), .rstPorN(rstPorN), .rstAnyN(rstAnyN), .stb(stb), .wrData(regWrData),
    .enXtalQ(enXtal), .lowPwrQ(xtalLowPwr), .en32kQ(en32k), .en128kQ(en128k),
    .selQ(selQ), .unlockQ(unlockQ), .trim128Q(trim128), .trim16Q(trim16)
  );

  osc_ctrl_prediv prediv_i (
    .clk(clk), .rstAnyN(rstAnyN), .restart(stb.restartDiv), .sel(selQ),
    .srcTick(srcTick), .rtcTick(rtcTick)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) begin
      regRdData[POS_XTAL]               = enXtal;
      regRdData[POS_LOWPWR]             = xtalLowPwr;
      regRdData[POS_32K]                = en32k;
      regRdData[POS_128K]               = en128k;
      regRdData[POS_SEL +: SEL_W]       = selQ;
      regRdData[POS_UNLOCK]             = unlockQ;
      regRdData[POS_T128 +: TRIM128_W]  = trim128;
      regRdData[POS_T16 +: TRIM16_W]    = trim16;
    end
  end
endmodule

// File: rtl/osc_ctrl_reg_chk.sv
module osc_ctrl_reg_chk
  import osc_ctrl_pkg::*;
(
  input logic                 clk,
  input logic                 rstSysN,
  input logic                 rstPorN,
  input logic                 regWrEn,
  input logic                 unlockQ,
  input logic [SEL_W-1:0]     selQ,
  input logic                 srcTick,
  input logic                 rtcTick,
  input logic                 en32k,
  input logic [TRIM128_W-1:0] trim128,
  input logic [TRIM16_W-1:0]  trim16
);
  AST_TRIM_LOCKED: assert property (@(posedge clk) disable iff (!rstPorN)
    !(regWrEn && unlockQ) |=> ($stable(trim128) && $stable(trim16)));       // R3

  AST_RETAIN_SYS: assert property (@(posedge clk) disable iff (!rstPorN)
    !rstSysN |=> ($stable(trim128) && $stable(trim16) && $stable(en32k)));  // R4

  AST_SEL_VALID: assert property (@(posedge clk) disable iff (!rstPorN)
    int'(selQ) <= MAX_SEL);                                                 // R6

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    rtcTick |-> srcTick);                                                   // R7

  AST_DIV1_PASS: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    (selQ == '0) |-> (rtcTick == srcTick));                                 // R7
endmodule

bind osc_ctrl_reg osc_ctrl_reg_chk chk_i (
  .clk(clk), .rstSysN(rstSysN), .rstPorN(rstPorN), .regWrEn(regWrEn),
  .unlockQ(unlockQ), .selQ(selQ), .srcTick(srcTick), .rtcTick(rtcTick),
  .en32k(en32k), .trim128(trim128), .trim16(trim16)
);

// File: tb/osc_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module osc_ctrl_reg_tb_top;
  localparam logic [31:0] POR_VAL  = 32'h003F_1F01;
  localparam logic [31:0] RET_MASK = 32'h003F_1F04;

  logic        clk = 0;
  logic        rstSysN = 1, rstPorN = 0;
  logic        regWrEn = 0;
  logic [7:0]  regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        srcTick = 0;
  logic        rtcTick, enXtal, xtalLowPwr, en32k, en128k;
  logic [4:0]  trim128;
  logic [5:0]  trim16;

  int checks = 0, errors = 0;
  logic [31:0] model;

  always #4 clk = ~clk;

  osc_ctrl_reg dut_i (
    .clk(clk), .rstSysN(rstSysN), .rstPorN(rstPorN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .srcTick(srcTick), .rtcTick(rtcTick), .enXtal(enXtal), .xtalLowPwr(xtalLowPwr),
    .en32k(en32k), .en128k(en128k), .trim128(trim128), .trim16(trim16)
  );

  function automatic logic [31:0] applyWrite(input logic [31:0] cur, input logic [31:0] d);
    logic [31:0] r = cur;
    r[3:0] = d[3:0];
    r[7]   = d[7];
    if (d[6:4] <= 3'd4) r[6:4] = d[6:4];
    if (cur[7]) begin
      r[12:8]  = d[12:8];
      r[21:16] = d[21:16];
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regAddr = 0;
    if (a == 0) model = applyWrite(model, d);
  endtask

  task automatic checkReg(input string tag);
    logic [31:0] pins;
    regAddr = 0;
    #1;
    check(regRdData === model, tag, regRdData, model);
    pins = {10'd0, trim16, 3'd0, trim128, 4'd0, en128k, en32k, xtalLowPwr, enXtal};
    check(pins === (model & 32'h003F_1F0F), "R2 pins", pins, model & 32'h003F_1F0F);
  endtask

  task automatic tickCycle(input logic t, input logic exp, input string tag);
    @(negedge clk);
    srcTick = t;
    #1;
    check(rtcTick === exp, tag, {31'd0, rtcTick}, {31'd0, exp});
    @(negedge clk);
    srcTick = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model = POR_VAL;
    repeat (3) @(negedge clk);
    rstPorN = 1;
    @(negedge clk);
    checkReg("R5 por value");

    regAddr = 8'h04; #1;
    check(regRdData === 0, "R1 other addr read", regRdData, 0);

    writeReg(8'h00, 32'hFFFF_FFFF);
    checkReg("R3 R6 R1 locked write");
    writeReg(8'h00, 32'h0015_0A80);
    checkReg("R3 unlocked write");
    writeReg(8'h08, 32'h0000_0000);
    checkReg("R1 other addr write");

    writeReg(8'h00, 32'h0007_0E84);
    @(negedge clk); rstSysN = 0;
    @(negedge clk); regWrEn = 1; regWrData = 32'h0; @(negedge clk); regWrEn = 0;
    rstSysN = 1;
    model = (model & RET_MASK) | 32'h1;
    @(negedge clk);
    checkReg("R4 system reset");

    @(negedge clk); rstPorN = 0; @(negedge clk); rstPorN = 1;
    model = POR_VAL;
    checkReg("R5 power-on reset");

    writeReg(8'h00, 32'h0000_0030);
    writeReg(8'h00, 32'h0000_0059);
    checkReg("R6 reserved code kept");

    for (int n = 0; n <= 4; n++) begin
      writeReg(8'h00, 32'h1 | (n << 4));
      for (int i = 0; i < (3 << n); i++) begin
        if ($urandom_range(0, 2) == 0) tickCycle(1'b0, 1'b0, "R7 no tick idle");
        tickCycle(1'b1, (i % (1 << n)) == ((1 << n) - 1), "R7 tick spacing");
      end
    end

    for (int i = 0; i < 5; i++) tickCycle(1'b1, 1'b0, "R8 pre-change");
    writeReg(8'h00, 32'h31);
    for (int i = 0; i < 8; i++) tickCycle(1'b1, i == 7, "R8 restart on change");
    for (int i = 0; i < 3; i++) tickCycle(1'b1, 1'b0, "R8 pre-same");
    writeReg(8'h00, 32'h31);
    for (int i = 0; i < 5; i++) tickCycle(1'b1, i == 4, "R8 same code no restart");

    for (int k = 0; k < 300; k++) begin
      logic [31:0] d = $urandom;
      logic [7:0]  a = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(1, 255)) : 8'h00;
      writeReg(a, d);
      checkReg("R1 R3 R6 random write");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule